// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the serial front end of a small byte-addressed nonvolatile memory that sits on a two-wire bus as a slave. The bus clock and data lines are brought into the system clock domain through a synchronizer. There they are oversampled to find clock edges and the two bus conditions that frame every transfer. The slave answers only when the address byte carries the fixed device-type prefix and a select field that matches three strap inputs. It then takes a byte address and data bytes for writing, or streams stored bytes back for reading.

One internal pointer serves both directions. A transfer that loads an address and then restarts in the read direction is a random read. A read that starts without a new address continues from where the last access left off. Write data collects in a page buffer and is committed to the array at Stop by a timed programming cycle. While that cycle runs, the slave refuses every address byte, so a host can poll until it is acknowledged again. The array is a plain register model with a configurable size of 128 or 256 bytes.

The output `sda_oe` is an open-drain pull-down enable. When it is 1 the pad pulls SDA low. When it is 0, SDA is released to its pull-up.

Top module: `eeprom_serial_slave`

## Requirements
- R1: SDA falling while SCL is high is a Start, and SDA rising while SCL is high is a Stop. Neither is ever taken as a data bit. A Stop ends the transfer, releases SDA and discards any byte in progress, so the pointer is left unchanged when the byte address was incomplete.
- R2: The first byte after a Start is sent MSB first. Bits 7..4 must be 1010, bits 3..1 must equal `dev_sel[2:0]` (bit 3 against `dev_sel[2]`), and bit 0 selects the direction (1 = read, 0 = write). On a mismatch the slave does not acknowledge and drives nothing until the next Start.
- R3: For every byte it accepts, the slave pulls SDA low for the whole ninth SCL clock. This covers the address byte, the byte address and each write data byte.
- R4: In a write, the second byte loads the pointer with its low log2(MEM_BYTES) bits. Each data byte is buffered at the pointer, and then the low log2(PAGE_BYTES) pointer bits increment and wrap inside the page while the upper bits stay fixed. The buffered bytes reach the array when the programming cycle that starts at Stop completes.
- R5: A read without a new byte address returns the byte at the pointer, which is the last accessed location plus one. After a write, that location is the next one inside the same page.
- R6: A write-direction transfer that carries only a byte address, followed by a repeated Start and a read-direction address byte, returns data starting at that byte address.
- R7: In a read, a master acknowledge after a data byte makes the slave send the byte at the next address. The address wraps from MEM_BYTES-1 to 0. A master non-acknowledge ends the transfer.
- R8: For PROG_CYCLES system clocks after a Stop that follows buffered write data, no address byte is acknowledged, even one that matches. After that, matching addresses are acknowledged again.
- R9: `sda_oe` changes only while SCL is low and is 0 out of reset. It is released right after each acknowledge clock and after the last data bit of a byte sent by the slave.
- R10: A Start seen in any state clears the bit count and returns the slave to address reception. When no programming cycle is running, it also discards write data buffered since the previous Start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad (wired-AND of all drivers) |
| dev_sel | input | 3 | Strap value compared with address bits 3..1 |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |

## Verification
The bound checker watches several properties on every cycle. It checks that the pull-down enable only moves while SCL is low and that it is released after a Stop. It checks that the enable is asserted only in acknowledge or transmit phases, that a Start always lands in address reception, and that no acknowledge rises while programming is busy. Stored values, pointer continuity, page wrap inside the write buffer, and array wraparound in sequential reads can only be shown by the bench's transfers. Discarding on a repeated Start and refusal of mismatched addresses are shown the same way, with results compared against a bench memory model.

// File: rtl/eeslv_pkg.sv
package eeslv_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int         BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_TX,
        ST_RACK
    } slv_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] sel);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == sel);
    endfunction

endpackage

// File: rtl/eeslv_line_cond.sv
module eeslv_line_cond
    import eeslv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_now;
    logic                   sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_now;
            sda_q    <= sda_now;
        end
    end

    assign scl_now = scl_sync[SYNC_STAGES-1];
    assign sda_now = sda_sync[SYNC_STAGES-1];

    always_comb begin
        ev.scl_rise = scl_now & ~scl_q;
        ev.scl_fall = ~scl_now & scl_q;
        ev.start    = scl_now & scl_q & sda_q & ~sda_now;
        ev.stop     = scl_now & scl_q & ~sda_q & sda_now;
        ev.sda      = sda_now;
    end

endmodule

// File: rtl/eeslv_proto_fsm.sv
module eeslv_proto_fsm
    import eeslv_pkg::*;
#(
    parameter  int MEM_BYTES  = 256,
    parameter  int PAGE_BYTES = 8,
    localparam int AW         = $clog2(MEM_BYTES),
    localparam int PW         = $clog2(PAGE_BYTES)
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_ev_t         ev,
    input  logic [2:0]      dev_sel,
    input  logic            busy,
    input  logic [7:0]      rd_data,
    output logic [AW-1:0]   rd_addr,
    output logic            push,
    output logic [AW-1:0]   push_addr,
    output logic [7:0]      push_data,
    output logic            commit,
    output logic            discard,
    output logic            sda_oe,
    output slv_state_e      state
);

    localparam logic [3:0] FULL = 4'(BYTE_BITS);
    localparam logic [3:0] LAST = 4'(BYTE_BITS - 1);

    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic [7:0]    txreg;
    logic [AW-1:0] ptr;
    logic          rw;
    logic          m_ack;

    assign rd_addr = ptr;

    always_ff @(posedge clk) begin
        push    <= 1'b0;
        commit  <= 1'b0;
        discard <= 1'b0;
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txreg     <= '0;
            ptr       <= '0;
            rw        <= 1'b0;
            m_ack     <= 1'b0;
            sda_oe    <= 1'b0;
            push_addr <= '0;
            push_data <= '0;
        end else if (ev.start) begin
            state   <= ST_DEV;
            bitcnt  <= '0;
            sda_oe  <= 1'b0;
            discard <= 1'b1;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            commit <= 1'b1;
        end else begin
            case (state)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (ev.scl_rise && (bitcnt < FULL)) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.scl_fall && (bitcnt == FULL)) begin
                        bitcnt <= '0;
                        if (state == ST_DEV) begin
                            if (dev_match(shreg, dev_sel) && !busy) begin
                                rw     <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_DEV_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_WADR) begin
                            ptr    <= shreg[AW-1:0];
                            sda_oe <= 1'b1;
                            state  <= ST_WADR_ACK;
                        end else begin
                            push      <= 1'b1;
                            push_addr <= ptr;
                            push_data <= shreg;
                            ptr       <= {ptr[AW-1:PW], PW'(ptr[PW-1:0] + 1'b1)};
                            sda_oe    <= 1'b1;
                            state     <= ST_WDAT_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (ev.scl_fall) begin
                        if (rw) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WADR;
                        end
                    end
                end
                ST_WADR_ACK, ST_WDAT_ACK: begin
                    if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WDAT;
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == LAST) begin
                            bitcnt <= '0;
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                            state  <= ST_RACK;
                        end else begin
                            bitcnt <= bitcnt + 4'd1;
                            sda_oe <= ~txreg[6];
                            txreg  <= {txreg[6:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        m_ack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (m_ack) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            state  <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/eeslv_store.sv
module eeslv_store #(
    parameter  int MEM_BYTES   = 256,
    parameter  int PAGE_BYTES  = 8,
    parameter  int PROG_CYCLES = 1500,
    localparam int AW          = $clog2(MEM_BYTES),
    localparam int PW          = $clog2(PAGE_BYTES),
    localparam int TW          = $clog2(PROG_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [7:0]    push_data,
    input  logic          commit,
    input  logic          discard,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy
);

    logic [7:0]            cells [MEM_BYTES];
    logic [7:0]            pbuf  [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic [AW-PW-1:0]      pbase;
    logic [TW-1:0]         tmr;

    assign busy    = (tmr != '0);
    assign rd_data = cells[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) cells[i] <= 8'hFF;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
            pvalid <= '0;
            pbase  <= '0;
            tmr    <= '0;
        end else begin
            if (discard && !busy) pvalid <= '0;
            if (push) begin
                pbuf[push_addr[PW-1:0]]   <= push_data;
                pvalid[push_addr[PW-1:0]] <= 1'b1;
                pbase                     <= push_addr[AW-1:PW];
            end
            if (commit && !busy && (pvalid != '0)) begin
                tmr <= TW'(PROG_CYCLES);
            end else if (tmr == TW'(1)) begin
                for (int i = 0; i < PAGE_BYTES; i++) begin
                    if (pvalid[i]) cells[{pbase, PW'(i)}] <= pbuf[i];
                end
                pvalid <= '0;
                tmr    <= '0;
            end else if (busy) begin
                tmr <= tmr - 1'b1;
            end
        end
    end

endmodule

// File: rtl/eeprom_serial_slave.sv
module eeprom_serial_slave
    import eeslv_pkg::*;
#(
    parameter  int MEM_BYTES   = 256,
    parameter  int PAGE_BYTES  = 8,
    parameter  int PROG_CYCLES = 1500,
    parameter  int SYNC_STAGES = 2,
    localparam int AW          = $clog2(MEM_BYTES)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] dev_sel,
    output logic       sda_oe
);

    bus_ev_t       line_ev;
    slv_state_e    fsm_state;
    logic          prog_busy;
    logic [7:0]    rd_data;
    logic [AW-1:0] rd_addr;
    logic          push;
    logic [AW-1:0] push_addr;
    logic [7:0]    push_data;
    logic          commit;
    logic          discard;

    eeslv_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (line_ev)
    );

    eeslv_proto_fsm #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (line_ev),
        .dev_sel   (dev_sel),
        .busy      (prog_busy),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .push      (push),
        .push_addr (push_addr),
        .push_data (push_data),
        .commit    (commit),
        .discard   (discard),
        .sda_oe    (sda_oe),
        .state     (fsm_state)
    );

    eeslv_store #(
        .MEM_BYTES   (MEM_BYTES),
        .PAGE_BYTES  (PAGE_BYTES),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_addr (push_addr),
        .push_data (push_data),
        .commit    (commit),
        .discard   (discard),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (prog_busy)
    );

endmodule

// File: rtl/eeslv_checker.sv
module eeslv_checker
    import eeslv_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_in,
    input logic       sda_oe,
    input logic       busy,
    input slv_state_e state,
    input logic       ev_start,
    input logic       ev_stop
);

    assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_in);

    assert_busy_nack_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !$rose(sda_oe));

    assert_start_resets_R10: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> (state == ST_DEV));

    assert_stop_release_R1: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> (!sda_oe && state == ST_IDLE));

    assert_oe_phase_R3: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state inside {ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK, ST_TX}));

endmodule

bind eeprom_serial_slave eeslv_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_oe   (sda_oe),
    .busy     (prog_busy),
    .state    (fsm_state),
    .ev_start (line_ev.start),
    .ev_stop  (line_ev.stop)
);

// File: tb/eeprom_serial_slave_test.sv
module eeprom_serial_slave_test;

    localparam int MEM_BYTES   = 256;
    localparam int PAGE_BYTES  = 8;
    localparam int PROG_CYCLES = 1500;
    localparam int Q           = 6;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;

    assign sda_line = m_sda & ~sda_oe;
    always #4 clk = ~clk;

    eeprom_serial_slave #(
        .MEM_BYTES   (MEM_BYTES),
        .PAGE_BYTES  (PAGE_BYTES),
        .PROG_CYCLES (PROG_CYCLES)
    ) uut (
        .clk     (clk),
        .rst     (rst),
        .scl_in  (scl),
        .sda_in  (sda_line),
        .dev_sel (STRAP),
        .sda_oe  (sda_oe)
    );

    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;
    logic [7:0] model [MEM_BYTES];
    int         mptr = 0;
    logic [7:0] wdata [PAGE_BYTES];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; q();
        scl = 1'b1;   q();
        m_sda = 1'b0; q();
        scl = 1'b0;   q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; q();
        scl = 1'b1;   q();
        m_sda = 1'b1; q();
    endtask

    task automatic wbit(input logic b);
        m_sda = b; q();
        scl = 1'b1; q();
        q();
        scl = 1'b0; q();
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; q();
        scl = 1'b1; q();
        b = sda_line; q();
        scl = 1'b0; q();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(~mack);
    endtask

    function automatic logic [7:0] devb(input logic rd);
        return {4'b1010, STRAP, rd};
    endfunction

    function automatic int page_slot(input int base, input int k);
        return (base & ~(PAGE_BYTES - 1)) | ((base + k) & (PAGE_BYTES - 1));
    endfunction

    // page write of n bytes from wdata; model updated for later reads
    task automatic write_seq(input int addr, input int n);
        logic ack;
        bus_start();
        send_byte(devb(1'b0), ack);
        check("R3 write address byte ack", ack, 1);
        send_byte(8'(addr), ack);
        check("R3 byte address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wdata[i], ack);
            check("R3 write data ack", ack, 1);
            model[page_slot(addr, i)] = wdata[i];
        end
        bus_stop();
        mptr = page_slot(addr, n);
    endtask

    task automatic wait_ready(output int polls);
        logic ack;
        polls = 0;
        ack = 1'b0;
        while (!ack && polls < 60) begin
            bus_start();
            send_byte(devb(1'b0), ack);
            bus_stop();
            polls++;
        end
    endtask

    task automatic read_body(input int n, input string req);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            recv_byte(d, (i != n - 1));
            check(req, d, model[mptr]);
            mptr = (mptr + 1) % MEM_BYTES;
        end
        check("R9 released after last data bit", sda_oe, 0);
        bus_stop();
    endtask

    task automatic rand_read(input int addr, input int n, input string req);
        logic ack;
        bus_start();
        send_byte(devb(1'b0), ack);
        check("R6 dummy write ack", ack, 1);
        send_byte(8'(addr), ack);
        check("R6 byte address ack", ack, 1);
        bus_start();
        send_byte(devb(1'b1), ack);
        check("R6 read address ack", ack, 1);
        mptr = addr;
        read_body(n, req);
    endtask

    task automatic cur_read(input int n, input string req);
        logic ack;
        bus_start();
        send_byte(devb(1'b1), ack);
        check("R5 current read ack", ack, 1);
        read_body(n, req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic b;
        logic [7:0] d;
        int polls;
        void'($urandom(32'd20240607));
        for (int i = 0; i < MEM_BYTES; i++) model[i] = 8'hFF;

        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        q();
        check("R9 reset state sda_oe", sda_oe, 0);

        // R2: wrong device type prefix
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0}, ack);
        check("R2 wrong prefix nack", ack, 0);
        bus_stop();
        // R2: wrong strap, read direction: nothing driven
        bus_start();
        send_byte({4'b1010, STRAP ^ 3'b010, 1'b1}, ack);
        check("R2 wrong strap nack", ack, 0);
        d = '0;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        check("R2 silent after mismatch", d, 8'hFF);
        bus_stop();

        // R4 / R8: byte write and polling
        wdata[0] = 8'hA5;
        write_seq(8'h10, 1);
        bus_start();
        send_byte(devb(1'b0), ack);
        bus_stop();
        check("R8 busy poll nack", ack, 0);
        wait_ready(polls);
        check("R8 ack after programming", (polls > 2 && polls < 60), 1);

        rand_read(8'h10, 1, "R6 random read data");
        cur_read(1, "R5 current address after read");

        // R4: page wrap of write pointer
        wdata[0] = 8'h11; wdata[1] = 8'h22; wdata[2] = 8'h33; wdata[3] = 8'h44;
        write_seq(8'h1E, 4);
        wait_ready(polls);
        rand_read(8'h18, 8, "R4 page wrap write readback");

        // R5: pointer after write wraps in page
        wdata[0] = 8'h6C;
        write_seq(8'h47, 1);
        wait_ready(polls);
        mptr = 8'h40;
        cur_read(1, "R5 current address after write");

        // R7: array wraparound in sequential read
        wdata[0] = 8'h5A;
        write_seq(8'hFF, 1);
        wait_ready(polls);
        wdata[0] = 8'hC3;
        write_seq(8'h00, 1);
        wait_ready(polls);
        rand_read(8'hFF, 3, "R7 sequential wrap");

        // R10: Start in mid-byte returns to address reception
        bus_start();
        wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b0);
        bus_start();
        send_byte(devb(1'b1), ack);
        check("R10 ack after aborted byte", ack, 1);
        read_body(1, "R10 data after abort");

        // R10: repeated Start discards buffered data
        bus_start();
        send_byte(devb(1'b0), ack);
        send_byte(8'h30, ack);
        send_byte(8'h77, ack);
        check("R10 data accepted before restart", ack, 1);
        bus_start();
        bus_stop();
        bus_start();
        send_byte(devb(1'b0), ack);
        bus_stop();
        check("R10 no programming after discard", ack, 1);
        rand_read(8'h30, 1, "R10 discarded data not stored");

        // R1: Stop inside the byte address leaves pointer unchanged
        bus_start();
        send_byte(devb(1'b0), ack);
        wbit(1'b0); wbit(1'b1); wbit(1'b1);
        bus_stop();
        check("R1 released after stop", sda_oe, 0);
        cur_read(1, "R1 stop aborts address byte");

        // constrained random page writes and readback
        for (int it = 0; it < 6; it++) begin
            int a;
            int n;
            a = int'($urandom % MEM_BYTES);
            n = 1 + int'($urandom % PAGE_BYTES);
            for (int k = 0; k < n; k++) wdata[k] = 8'($urandom);
            write_seq(a, n);
            wait_ready(polls);
            check("R8 random ready", (polls < 60), 1);
            rand_read(a & ~(PAGE_BYTES - 1), PAGE_BYTES, "R4 random page readback");
            cur_read(2, "R7 random sequential continue");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule